// File: doc/BRIEF.md
# Receive FIFO with Error Tracking

This block is the receive queue that sits between a serial deserialiser and the processor-facing line-status logic of a UART channel. Each entry holds one received character and three error flags: break, framing and parity. The deserialiser pushes a character together with its flags. The processor pops the head with a holding-register read strobe.

The block shows the head character and that character's own error flags. It also drives a summary error bit, which stays high while any stored entry anywhere in the queue carries an error. This bit is kept by a running count of flagged entries. The block also drives a data-ready bit, the fill level, and a sticky overrun flag. A write that arrives while the queue is full sets the overrun flag and is discarded. A read of the line-status register clears the flag. A synchronous clear input empties the whole queue in a single cycle.

Top module: `rx_err_fifo`

## Requirements
- R1: The queue holds up to DEPTH (default 64) characters in first-in first-out order. A write with `wrValid` high is stored when the queue is not full, and `fillCount` reports the number of stored entries.
- R2: `errAny` is high while at least one stored entry has any of its break, framing or parity flags set. It goes low only when no such entry remains.
- R3: `headData`, `headBrk`, `headFrm` and `headPar` show the character and flags of the entry at the head of the queue. All of them are zero when the queue is empty.
- R4: A cycle with `rhrRead` high removes the head entry, and the head outputs move to the next entry. `rhrRead` on an empty queue has no effect.
- R5: A write while the queue is full sets `overrun`, and the incoming character is discarded. Fullness is judged on the state before any read in the same cycle, so a simultaneous read still pops but the write is lost. The stored contents are not changed.
- R6: `lsrRead` clears `overrun`. If a new overrun occurs in the same cycle as `lsrRead`, the flag stays set.
- R7: `dataReady` is high exactly when `fillCount` is non-zero.
- R8: `fifoClear` empties the queue, zeroes the error-entry count and clears `overrun` in one cycle. It takes priority over any write or read in that cycle.
- R9: A simultaneous write and read of flagged characters leaves the error count, and so `errAny`, consistent. `fillCount` is unchanged when the queue is neither empty nor full.
- R10: `rstN` low asynchronously empties the queue and clears `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fifoClear | input | 1 | Synchronous flush of all entries and flags |
| wrValid | input | 1 | Write strobe from deserialiser |
| wrData | input | DATA_W | Received character |
| wrBrk | input | 1 | Break flag of the written character |
| wrFrm | input | 1 | Framing-error flag of the written character |
| wrPar | input | 1 | Parity-error flag of the written character |
| rhrRead | input | 1 | Holding-register read strobe (pops head) |
| lsrRead | input | 1 | Line-status read strobe (clears overrun) |
| headData | output | DATA_W | Character at the head, zero when empty |
| headBrk | output | 1 | Break flag of the head character |
| headFrm | output | 1 | Framing flag of the head character |
| headPar | output | 1 | Parity flag of the head character |
| errAny | output | 1 | Some stored entry carries an error |
| overrun | output | 1 | Sticky overrun flag |
| dataReady | output | 1 | Queue not empty |
| fillCount | output | $clog2(DEPTH+1) | Number of stored entries |

## Verification
Every strobe is sampled on a rising edge, and every result appears a short time after that same edge. The head outputs, `errAny`, `fillCount`, `dataReady` and `overrun` all reflect a write, a pop, a status read or a clear exactly one edge after the strobe was presented. The bench drives inputs on the falling edge and advances its reference queue at the same moment. It then compares every output 1 ns after the next rising edge, so each result is checked in the first cycle it is due. The reference derives `errAny` by scanning its own stored flags rather than keeping a counter.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rxq_flags_t;

  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } rxq_strobes_t;

endpackage

// File: rtl/rxq_datapath.sv
module rxq_datapath
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxq_strobes_t      strb,
  input  logic              fifoEmpty,
  input  logic [DATA_W-1:0] inData,
  input  rxq_flags_t        inFlags,
  output logic [DATA_W-1:0] headData,
  output rxq_flags_t        headFlags,
  output logic              headHasErr
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] dataMem [DEPTH];
  rxq_flags_t        flagMem [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strb.push) begin
      dataMem[wrPtr] <= inData;
      flagMem[wrPtr] <= inFlags;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (strb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.push) wrPtr <= stepPtr(wrPtr);
      if (strb.pop)  rdPtr <= stepPtr(rdPtr);
    end
  end

  rxq_flags_t rawFlags;
  always_comb begin
    rawFlags   = flagMem[rdPtr];
    headHasErr = rawFlags.brk | rawFlags.frm | rawFlags.par;
    headData   = fifoEmpty ? '0 : dataMem[rdPtr];
    headFlags  = fifoEmpty ? '0 : rawFlags;
  end

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       fifoClear,
  input  logic                       wrValid,
  input  logic                       wrHasErr,
  input  logic                       rhrRead,
  input  logic                       lsrRead,
  input  logic                       headHasErr,
  output rxq_strobes_t               strb,
  output logic                       fifoEmpty,
  output logic [$clog2(DEPTH+1)-1:0] fillCount,
  output logic                       errAny,
  output logic                       overrun,
  output logic                       dataReady
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] errCnt;
  logic             full;
  logic             errInc;
  logic             errDec;

  always_comb begin
    full       = (count == CNT_W'(DEPTH));
    fifoEmpty  = (count == '0);
    strb.flush = fifoClear;
    strb.push  = wrValid && !full && !fifoClear;
    strb.pop   = rhrRead && !fifoEmpty && !fifoClear;
    errInc     = strb.push && wrHasErr;
    errDec     = strb.pop && headHasErr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      errCnt  <= '0;
      overrun <= 1'b0;
    end else if (fifoClear) begin
      count   <= '0;
      errCnt  <= '0;
      overrun <= 1'b0;
    end else begin
      case ({strb.push, strb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (errInc && !errDec)      errCnt <= errCnt + 1'b1;
      else if (errDec && !errInc) errCnt <= errCnt - 1'b1;
      if (wrValid && full) overrun <= 1'b1;
      else if (lsrRead)    overrun <= 1'b0;
    end
  end

  assign fillCount = count;
  assign errAny    = (errCnt != '0);
  assign dataReady = !fifoEmpty;

endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       fifoClear,
  input  logic                       wrValid,
  input  logic [DATA_W-1:0]          wrData,
  input  logic                       wrBrk,
  input  logic                       wrFrm,
  input  logic                       wrPar,
  input  logic                       rhrRead,
  input  logic                       lsrRead,
  output logic [DATA_W-1:0]          headData,
  output logic                       headBrk,
  output logic                       headFrm,
  output logic                       headPar,
  output logic                       errAny,
  output logic                       overrun,
  output logic                       dataReady,
  output logic [$clog2(DEPTH+1)-1:0] fillCount
);

  rxq_strobes_t strb;
  rxq_flags_t   inFlags;
  rxq_flags_t   headFlags;
  logic         fifoEmpty;
  logic         headHasErr;

  assign inFlags = '{brk: wrBrk, frm: wrFrm, par: wrPar};

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .fifoClear  (fifoClear),
    .wrValid    (wrValid),
    .wrHasErr   (wrBrk | wrFrm | wrPar),
    .rhrRead    (rhrRead),
    .lsrRead    (lsrRead),
    .headHasErr (headHasErr),
    .strb       (strb),
    .fifoEmpty  (fifoEmpty),
    .fillCount  (fillCount),
    .errAny     (errAny),
    .overrun    (overrun),
    .dataReady  (dataReady)
  );

  rxq_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .fifoEmpty  (fifoEmpty),
    .inData     (wrData),
    .inFlags    (inFlags),
    .headData   (headData),
    .headFlags  (headFlags),
    .headHasErr (headHasErr)
  );

  assign headBrk = headFlags.brk;
  assign headFrm = headFlags.frm;
  assign headPar = headFlags.par;

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DEPTH = 64
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       fifoClear,
  input logic                       wrValid,
  input logic                       rhrRead,
  input logic                       lsrRead,
  input logic                       headBrk,
  input logic                       headFrm,
  input logic                       headPar,
  input logic                       errAny,
  input logic                       overrun,
  input logic [$clog2(DEPTH+1)-1:0] fillCount
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULLV = CNT_W'(DEPTH);

  a_r1_bound: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= FULLV);

  a_r2_err_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    (fillCount == '0) |-> !errAny);

  a_r3_flags_zero_empty: assert property (@(posedge clk) disable iff (!rstN)
    (fillCount == '0) |-> !(headBrk || headFrm || headPar));

  a_r2_head_err_seen: assert property (@(posedge clk) disable iff (!rstN)
    (headBrk || headFrm || headPar) |-> errAny);

  a_r4_empty_read: assert property (@(posedge clk) disable iff (!rstN)
    (fillCount == '0 && rhrRead && !wrValid && !fifoClear) |=> (fillCount == '0));

  a_r5_overrun_set: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && fillCount == FULLV && !fifoClear) |=> overrun);

  a_r5_contents_kept: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && fillCount == FULLV && !rhrRead && !fifoClear) |=> (fillCount == FULLV));

  a_r6_lsr_clear: assert property (@(posedge clk) disable iff (!rstN)
    (lsrRead && !wrValid && !fifoClear) |=> !overrun);

  a_r8_flush: assert property (@(posedge clk) disable iff (!rstN)
    fifoClear |=> (fillCount == '0 && !errAny && !overrun));

endmodule

bind rx_err_fifo rxq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .fifoClear (fifoClear),
  .wrValid   (wrValid),
  .rhrRead   (rhrRead),
  .lsrRead   (lsrRead),
  .headBrk   (headBrk),
  .headFrm   (headFrm),
  .headPar   (headPar),
  .errAny    (errAny),
  .overrun   (overrun),
  .fillCount (fillCount)
);

// File: tb/rx_err_fifo_tb.sv
`timescale 1ns/1ps
module rx_err_fifo_tb;

  localparam int DEPTH  = 64;
  localparam int DATA_W = 8;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fifoClear = 1'b0, wrValid = 1'b0, rhrRead = 1'b0, lsrRead = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic wrBrk = 1'b0, wrFrm = 1'b0, wrPar = 1'b0;
  logic [DATA_W-1:0] headData;
  logic headBrk, headFrm, headPar, errAny, overrun, dataReady;
  logic [CNT_W-1:0] fillCount;

  int checks = 0;
  int errors = 0;

  // reference model: entry = {brk, frm, par, data}
  logic [DATA_W+2:0] mq[$];
  logic mOvr = 1'b0;

  always #2.5 clk = ~clk;

  rx_err_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rstN(rstN), .fifoClear(fifoClear), .wrValid(wrValid),
    .wrData(wrData), .wrBrk(wrBrk), .wrFrm(wrFrm), .wrPar(wrPar),
    .rhrRead(rhrRead), .lsrRead(lsrRead), .headData(headData),
    .headBrk(headBrk), .headFrm(headFrm), .headPar(headPar),
    .errAny(errAny), .overrun(overrun), .dataReady(dataReady),
    .fillCount(fillCount)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic modelErrAny();
    for (int i = 0; i < mq.size(); i++)
      if (mq[i][DATA_W+2:DATA_W] != 3'b000) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [DATA_W+2:0] modelHead();
    return (mq.size() == 0) ? '0 : mq[0];
  endfunction

  task automatic checkAll(input string tag);
    logic [DATA_W+2:0] h;
    h = modelHead();
    check(fillCount == CNT_W'(mq.size()), {tag, " R1 fillCount"}, fillCount, mq.size());
    check(headData == h[DATA_W-1:0], {tag, " R3 headData"}, headData, h[DATA_W-1:0]);
    check({headBrk, headFrm, headPar} == h[DATA_W+2:DATA_W], {tag, " R3 head flags"},
          {headBrk, headFrm, headPar}, h[DATA_W+2:DATA_W]);
    check(errAny == modelErrAny(), {tag, " R2 errAny"}, errAny, modelErrAny());
    check(overrun == mOvr, {tag, " R5/R6 overrun"}, overrun, mOvr);
    check(dataReady == (mq.size() != 0), {tag, " R7 dataReady"}, dataReady, mq.size() != 0);
  endtask

  // one clock: drive on falling edge, model next state, check after rising edge
  task automatic step(input logic wv, input logic [DATA_W-1:0] d, input logic [2:0] fl,
                      input logic rr, input logic lr, input logic clr, input string tag);
    logic wasFull, wasEmpty;
    @(negedge clk);
    wrValid = wv; wrData = d; {wrBrk, wrFrm, wrPar} = fl;
    rhrRead = rr; lsrRead = lr; fifoClear = clr;
    wasFull  = (mq.size() == DEPTH);
    wasEmpty = (mq.size() == 0);
    if (clr) begin
      mq.delete();
      mOvr = 1'b0;
    end else begin
      if (rr && !wasEmpty) void'(mq.pop_front());
      if (wv && !wasFull) mq.push_back({fl, d});
      if (wv && wasFull) mOvr = 1'b1;
      else if (lr) mOvr = 1'b0;
    end
    @(posedge clk);
    #1;
    checkAll(tag);
  endtask

  task automatic randPhase(input int n, input int pw, input int pr, input int pe,
                           input int pl, input string tag);
    for (int i = 0; i < n; i++) begin
      logic [2:0] fl;
      fl = (($urandom % 100) < pe) ? 3'($urandom % 7 + 1) : 3'b000;
      step(($urandom % 100) < pw, DATA_W'($urandom), fl, ($urandom % 100) < pr,
           ($urandom % 100) < pl, ($urandom % 400) == 0, tag);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    checkAll("reset R10");
    @(negedge clk);
    rstN = 1'b1;

    // R4: read of empty queue ignored
    step(1'b0, '0, 3'b000, 1'b1, 1'b0, 1'b0, "R4 empty read");
    // R1/R3: simple write then head tracking
    step(1'b1, 8'hA5, 3'b000, 1'b0, 1'b0, 1'b0, "R1 first write");
    step(1'b1, 8'h3C, 3'b010, 1'b0, 1'b0, 1'b0, "R2 flagged write");
    step(1'b1, 8'h77, 3'b000, 1'b1, 1'b0, 1'b0, "R9 push+pop");
    step(1'b0, '0, 3'b000, 1'b1, 1'b0, 1'b0, "R2 R4 pop flagged head");
    step(1'b0, '0, 3'b000, 1'b1, 1'b0, 1'b0, "R2 clean after pop");

    // fill to full with mixed flags
    for (int i = 0; i < DEPTH; i++)
      step(1'b1, DATA_W'(i + 16), (i % 9 == 4) ? 3'b100 : 3'b000, 1'b0, 1'b0, 1'b0, "R1 fill");
    step(1'b1, 8'hEE, 3'b001, 1'b0, 1'b0, 1'b0, "R5 overrun discard");
    step(1'b1, 8'hEF, 3'b001, 1'b1, 1'b1, 1'b0, "R5 R6 overrun wins with read");
    step(1'b0, '0, 3'b000, 1'b0, 1'b1, 1'b0, "R6 lsr clears");
    for (int i = 0; i < DEPTH + 2; i++)
      step(1'b0, '0, 3'b000, 1'b1, 1'b0, 1'b0, "R4 drain");

    // R8 flush with simultaneous write and read
    for (int i = 0; i < 10; i++)
      step(1'b1, DATA_W'(i), 3'b011, 1'b0, 1'b0, 1'b0, "R2 load");
    step(1'b1, 8'h55, 3'b001, 1'b1, 1'b0, 1'b1, "R8 flush priority");

    randPhase(1500, 70, 30, 30, 10, "R1 R5 fill-biased");
    randPhase(1500, 40, 60, 50, 20, "R2 R4 drain-biased");
    randPhase(1500, 50, 50, 80, 50, "R9 balanced");

    // R10 asynchronous reset mid-run
    for (int i = 0; i < 5; i++)
      step(1'b1, DATA_W'(i), 3'b100, 1'b0, 1'b0, 1'b0, "R2 preload");
    @(negedge clk);
    wrValid = 1'b0; rhrRead = 1'b0; lsrRead = 1'b0; fifoClear = 1'b0;
    #1 rstN = 1'b0;
    mq.delete();
    mOvr = 1'b0;
    #1;
    checkAll("R10 async reset");
    @(negedge clk);
    rstN = 1'b1;
    step(1'b1, 8'h9A, 3'b000, 1'b0, 1'b0, 1'b0, "R10 after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule